// File: doc/BRIEF.md
# Valley-Aligned Event Delay Unit

This block takes a single-cycle event pulse that has already passed an edge filter and re-issues it as a single-cycle synchronisation pulse for a PWM time-base. The pulse is delayed by a number of clock cycles taken from a measured oscillation period. Software can scale that period down by a power of two and can add an offset to it, so that the sync lands on a resonant valley instead of on a peak.

When an event is accepted, the block computes the delay from the period, offset, divider and mode inputs present in that cycle and latches it. A down-counter then runs out the delay and the block emits one output pulse. A second event that arrives while a delay is still pending is dropped. A select input can bypass the computed delay, and the event then passes with the minimum latency.

The controller has three named states. In `ST_IDLE` it waits for an event. `ST_COUNT` runs the counter. `ST_FIRE` is the single cycle in which the output is high. An event in `ST_IDLE` takes the *start-fire* transition to `ST_FIRE` if the delay is zero or the bypass is selected. Otherwise it takes the *start-count* transition to `ST_COUNT`. `ST_COUNT` stays in place until the counter holds 1, and then takes the *expire* transition to `ST_FIRE`. `ST_FIRE` always takes the *finish* transition back to `ST_IDLE`.

Top module: `valley_delay_unit`

## Requirements
- R1: While reset is active, and in the first cycle after reset, `sync_out` is low.
- R2: With `hw_dly_en`=1, `offset_en`=0 and `div_sel`=0, `sync_out` is high in exactly the cycle that comes D+1 cycles after the cycle in which `evt_in` was high, where D equals `period_in`.
- R3: With `offset_en`=1, D is the scaled period plus `offset_in`.
- R4: `div_sel` sets the right shift applied to `period_in`, with truncation, before the offset is added. The codes are 0→/1, 1→/2, 2→/4 and 3→/8. Code 4 and the codes 5 to 7 all select /16.
- R5: When the sum of the scaled period and the offset exceeds 65535, D saturates to 65535.
- R6: With `hw_dly_en`=0, `sync_out` is high in the cycle right after the event, whatever the period, offset, divider and offset mode are.
- R7: A computed D of zero gives `sync_out` in the cycle right after the event.
- R8: Every output pulse lasts exactly one cycle, and each accepted event gives exactly one pulse.
- R9: An `evt_in` that arrives while a delay is pending is ignored. This includes an event in the cycle in which `sync_out` is high. Such an event gives no further pulse and does not change the timing of the pending one.
- R10: The delay inputs are latched in the cycle of the event. Changes to them during the countdown do not affect the pending pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 1 | Filtered event pulse, one cycle |
| period_in | input | 16 | Captured oscillation period, in cycles |
| offset_in | input | 16 | Software offset, in cycles |
| div_sel | input | 3 | Period divider code |
| offset_en | input | 1 | Add the offset to the scaled period |
| hw_dly_en | input | 1 | 1: apply the computed delay; 0: bypass it |
| sync_out | output | 1 | Delayed single-cycle sync pulse |

## Verification
The clash that matters is a new event that arrives in the same cycle as the output pulse of the previous one. At that moment the controller is finishing in `ST_FIRE` and could be tempted to re-arm. The bench drives a stray event exactly in the cycle where it sees `sync_out` high, and drives another one partway through the countdown. It then watches for longer than the stray event's own computed delay plus the output latency, and requires `sync_out` to stay low. The pulse timing is compared with a latency computed by a bench function from the latched inputs, while the inputs are scrambled after each event.

// File: rtl/vdu_pkg.sv
package vdu_pkg;
    localparam int VDU_DATA_W  = 16;
    localparam int VDU_DIV_W   = 3;
    localparam int VDU_MAX_SHF = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FIRE  = 2'd2
    } vdu_state_e;
endpackage

// File: rtl/vdu_delay_calc.sv
module vdu_delay_calc #(
    parameter int W       = 16,
    parameter int DIV_W   = 3,
    parameter int MAX_SHF = 4
) (
    input  logic [W-1:0]     period_in,
    input  logic [W-1:0]     offset_in,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             offset_en,
    output logic [W-1:0]     delay_out
);
    localparam logic [DIV_W-1:0] SHF_CAP = DIV_W'(MAX_SHF);

    logic [W-1:0]     shifted [0:MAX_SHF];
    logic [DIV_W-1:0] shf_idx;
    logic [W-1:0]     scaled;
    logic [W-1:0]     addend;
    logic [W:0]       wide_sum;

    for (genvar g = 0; g <= MAX_SHF; g++) begin : g_shift
        assign shifted[g] = period_in >> g;
    end

    assign shf_idx = (div_sel > SHF_CAP) ? SHF_CAP : div_sel;

    always_comb begin
        scaled = shifted[0];
        for (int i = 0; i <= MAX_SHF; i++) begin
            if (shf_idx == DIV_W'(i)) scaled = shifted[i];
        end
    end

    assign addend   = offset_en ? offset_in : '0;
    assign wide_sum = {1'b0, scaled} + {1'b0, addend};
    assign delay_out = wide_sum[W] ? {W{1'b1}} : wide_sum[W-1:0];

    // Saturating add never wraps below either operand
    always_comb begin
        assert_sat_ge_scaled_R5: assert (delay_out >= scaled);
        assert_sat_ge_offset_R5: assert (delay_out >= addend);
    end
endmodule

// File: rtl/vdu_down_counter.sv
module vdu_down_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         at_one
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign at_one = (cnt_q == W'(1));

    // R10: once loaded, the count moves only downward by one per step
    assert_count_steps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && dec && cnt_q > W'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/valley_delay_unit.sv
module valley_delay_unit
    import vdu_pkg::*;
#(
    parameter int W       = VDU_DATA_W,
    parameter int DIV_W   = VDU_DIV_W,
    parameter int MAX_SHF = VDU_MAX_SHF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_in,
    input  logic [W-1:0]     period_in,
    input  logic [W-1:0]     offset_in,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             offset_en,
    input  logic             hw_dly_en,
    output logic             sync_out
);
    vdu_state_e   state_q, state_d;
    logic [W-1:0] calc_dly;
    logic [W-1:0] eff_dly;
    logic         accept;
    logic         cnt_load;
    logic         cnt_dec;
    logic         cnt_at_one;

    vdu_delay_calc #(
        .W(W), .DIV_W(DIV_W), .MAX_SHF(MAX_SHF)
    ) calc_i (
        .period_in (period_in),
        .offset_in (offset_in),
        .div_sel   (div_sel),
        .offset_en (offset_en),
        .delay_out (calc_dly)
    );

    assign eff_dly = hw_dly_en ? calc_dly : '0;
    assign accept  = (state_q == ST_IDLE) && evt_in;

    vdu_down_counter #(.W(W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (eff_dly),
        .dec      (cnt_dec),
        .at_one   (cnt_at_one)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (evt_in) begin
                    state_d = (eff_dly == '0) ? ST_FIRE : ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (cnt_at_one) state_d = ST_FIRE;
            end
            ST_FIRE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and counter controls
    always_comb begin
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        sync_out = 1'b0;
        unique case (state_q)
            ST_IDLE:  cnt_load = accept;
            ST_COUNT: cnt_dec  = 1'b1;
            ST_FIRE:  sync_out = 1'b1;
            default: ;
        endcase
    end

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |=> !sync_out);

    assert_bypass_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && evt_in && !hw_dly_en) |=> sync_out);

    assert_zero_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && evt_in && calc_dly == '0) |=> sync_out);

    assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRE && evt_in) |=> (state_q == ST_IDLE));

    assert_count_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && !cnt_at_one) |=> (state_q == ST_COUNT));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !sync_out);
endmodule

// File: tb/valley_delay_unit_tb_top.sv
module valley_delay_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_in = 1'b0;
    logic [15:0] period_in = '0;
    logic [15:0] offset_in = '0;
    logic [2:0]  div_sel = '0;
    logic        offset_en = 1'b0;
    logic        hw_dly_en = 1'b1;
    logic        sync_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    valley_delay_unit dut_i (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .period_in(period_in), .offset_in(offset_in), .div_sel(div_sel),
        .offset_en(offset_en), .hw_dly_en(hw_dly_en), .sync_out(sync_out)
    );

    function automatic int exp_delay(input logic [15:0] p, input logic [15:0] o,
                                     input logic [2:0] d, input bit oe, input bit he);
        int sh, s;
        if (!he) return 0;
        sh = (d > 3'd4) ? 4 : int'(d);
        s  = int'(p) >> sh;
        if (oe) s = s + int'(o);
        if (s > 65535) s = 65535;
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // One event; latency must be D+1 sampled cycles; strays and scrambles optional
    task automatic run_evt(input logic [15:0] p, input logic [15:0] o, input logic [2:0] d,
                           input bit oe, input bit he, input bit stray, input bit scramble,
                           input string req);
        int expd, n, lim;
        bit seen;
        expd = exp_delay(p, o, d, oe, he);
        @(negedge clk);
        period_in = p; offset_in = o; div_sel = d; offset_en = oe; hw_dly_en = he;
        evt_in = 1'b1;
        @(negedge clk);
        evt_in = 1'b0;
        if (scramble) begin   // R10: inputs change after latch
            period_in = 16'($urandom_range(0, 300));
            offset_in = 16'($urandom_range(0, 300));
            div_sel   = 3'($urandom);
            offset_en = 1'($urandom);
            hw_dly_en = 1'($urandom);
        end
        n = 1;
        seen = 1'b0;
        lim = expd + 3;
        while (n <= lim && !seen) begin
            if (sync_out) seen = 1'b1;
            else begin
                if (stray && n == 2) evt_in = 1'b1;   // R9: mid-countdown stray
                @(negedge clk);
                evt_in = 1'b0;
                n++;
            end
        end
        check(seen && n == expd + 1, req, seen ? n : -1, expd + 1);
        // collision: stray event in the pulse cycle (R9)
        if (stray) evt_in = 1'b1;
        @(negedge clk);
        evt_in = 1'b0;
        check(sync_out == 1'b0, "R8 pulse width", int'(sync_out), 0);
        if (stray) begin
            seen = 1'b0;
            for (int k = 0; k < 700; k++) begin
                if (sync_out) seen = 1'b1;
                @(negedge clk);
            end
            check(!seen, "R9 stray event ignored", int'(seen), 0);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(sync_out == 1'b0, "R1 reset low", int'(sync_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sync_out == 1'b0, "R1 after reset", int'(sync_out), 0);

        run_evt(16'd37, 16'd0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R2 period as is");
        run_evt(16'd1,  16'd0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R2 period one");
        run_evt(16'd20, 16'd15, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R3 period plus offset");
        run_evt(16'd100, 16'd9, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0, "R3 fraction plus offset");
        run_evt(16'd99, 16'd0, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, "R4 div2 truncate");
        run_evt(16'd95, 16'd0, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, "R4 div8");
        run_evt(16'd100, 16'd0, 3'd4, 1'b0, 1'b1, 1'b0, 1'b0, "R4 div16");
        run_evt(16'd100, 16'd0, 3'd7, 1'b0, 1'b1, 1'b0, 1'b0, "R4 code7 is div16");
        run_evt(16'd250, 16'd40, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, "R6 bypass");
        run_evt(16'd0, 16'd0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R7 zero delay");
        run_evt(16'd7, 16'd0, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, "R7 shifted to zero");
        run_evt(16'd60, 16'd5, 3'd1, 1'b1, 1'b1, 1'b1, 1'b1, "R9 R10 stray and scramble");
        run_evt(16'd0, 16'd0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, "R9 stray in fire cycle");

        for (int i = 0; i < 40; i++) begin
            run_evt(16'($urandom_range(0, 400)), 16'($urandom_range(0, 200)), 3'($urandom),
                    1'($urandom), 1'($urandom_range(0, 3) != 0), 1'($urandom),
                    1'($urandom), "R2 R3 R4 random");
        end

        run_evt(16'hFFFF, 16'h0010, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R5 saturation");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule